// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement State

This block holds the replacement state for every set of a four-way set-associative cache and names the way to evict on a miss. It does not track a full recency order. Each set keeps three bits arranged as a two-level binary decision tree. The root bit chooses a pair of ways. Each of the two leaf bits chooses one way within its own pair.

The cache controller drives an access strobe on every hit or fill, together with the set index and the way that was touched. The block then moves the two tree bits on that way's path so that they point away from it. Separately, the controller presents a set index on the query port and reads the victim way. The victim is computed combinationally from the stored state of that set. The tree always names either the least or the second-least recently used way of the set.

Top module: `plru_tree_repl`

## Requirements
- R1: A synchronous active-high reset clears every set's three tree bits. After reset, the victim for every set is way 0.
- R2: The victim is encoded as {root, root ? upper_leaf : lower_leaf}. A tree bit of 0 points at the lower-numbered half or way, and 1 points at the upper one. Ways are numbered 0 to 3. Way bit 1 selects the pair {2,3}.
- R3: An access to way w sets root = ~w[1]. If w[1] is 0 it sets lower_leaf = ~w[0]; otherwise it sets upper_leaf = ~w[0]. The leaf on the other pair keeps its value.
- R4: After an access, the victim of that set is never the way just accessed.
- R5: Treat the reset state as a recency order of 3, 1, 2, 0 (most to least recent). From that starting order, the victim is always one of the two least recently accessed ways of its set.
- R6: An access to one set leaves the victim of every other set unchanged.
- R7: While the access strobe is low, no set's state changes.
- R8: An access takes effect on the clock edge that samples the strobe. During the strobe cycle, a query of the same set still returns the victim from the old state.
- R9: A reset asserted in the middle of operation returns every set to the state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 2 | Way touched by the access |
| qry_set | input | SET_W | Set index whose victim is requested |
| victim | output | 2 | Way to replace in set qry_set |

## Verification
The bound checker watches every cycle for four things:
- the victim is way 0 right after reset;
- the victim never lands in the pair of, and never on, the way just accessed when that same set is queried;
- the victim stays steady with no access;
- the victim stays steady under accesses to other sets.

Only the bench scenarios can show the rest. These are the exact leaf encoding and which leaf survives an access, the old-state read during the strobe cycle, and a mid-run reset. They also include the bound to the two least recent ways, which needs a recency list for each set that the bench keeps.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;

  typedef logic [WAY_W-1:0] way_t;

  typedef struct packed {
    logic root;   // 0: pair {0,1}, 1: pair {2,3}
    logic lo;     // within {0,1}: 0 -> way 0, 1 -> way 1
    logic hi;     // within {2,3}: 0 -> way 2, 1 -> way 3
  } tree_t;

  localparam int TREE_W = $bits(tree_t);
endpackage

// File: rtl/plru_state_store.sv
module plru_state_store
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int SET_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  tree_t            wr_data,
  input  logic [SET_W-1:0] rd_a_set,
  output tree_t            rd_a_data,
  input  logic [SET_W-1:0] rd_b_set,
  output tree_t            rd_b_data
);
  tree_t state_q [NUM_SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SETS; i++) begin
        state_q[i] <= '0;
      end
    end else if (wr_en) begin
      state_q[wr_set] <= wr_data;
    end
  end

  assign rd_a_data = state_q[rd_a_set];
  assign rd_b_data = state_q[rd_b_set];
endmodule

// File: rtl/plru_path_update.sv
module plru_path_update
  import plru_pkg::*;
(
  input  tree_t cur,
  input  way_t  way,
  output tree_t nxt
);
  always_comb begin
    nxt      = cur;
    nxt.root = ~way[1];
    if (way[1]) begin
      nxt.hi = ~way[0];
    end else begin
      nxt.lo = ~way[0];
    end
  end
endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
  import plru_pkg::*;
(
  input  tree_t tree,
  output way_t  way
);
  always_comb begin
    way[1] = tree.root;
    way[0] = tree.root ? tree.hi : tree.lo;
  end
endmodule

// File: rtl/plru_tree_repl.sv
module plru_tree_repl
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic [SET_W-1:0] acc_set,
  input  logic [1:0]       acc_way,
  input  logic [SET_W-1:0] qry_set,
  output logic [1:0]       victim
);
  tree_t acc_cur;
  tree_t acc_nxt;
  tree_t qry_cur;
  way_t  pick;

  plru_state_store #(
    .NUM_SETS (NUM_SETS),
    .SET_W    (SET_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (acc_en),
    .wr_set    (acc_set),
    .wr_data   (acc_nxt),
    .rd_a_set  (acc_set),
    .rd_a_data (acc_cur),
    .rd_b_set  (qry_set),
    .rd_b_data (qry_cur)
  );

  plru_path_update u_update (
    .cur (acc_cur),
    .way (acc_way),
    .nxt (acc_nxt)
  );

  plru_victim_pick u_pick (
    .tree (qry_cur),
    .way  (pick)
  );

  assign victim = pick;
endmodule

// File: rtl/plru_tree_repl_chk.sv
module plru_tree_repl_chk #(
  parameter int SET_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_en,
  input logic [SET_W-1:0] acc_set,
  input logic [1:0]       acc_way,
  input logic [SET_W-1:0] qry_set,
  input logic [1:0]       victim
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  p_reset_way0_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> victim == 2'd0);

  p_pair_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(acc_en) && qry_set == $past(acc_set))
      |-> victim[1] != $past(acc_way[1]));

  p_not_mru_r4: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(acc_en) && qry_set == $past(acc_set))
      |-> victim != $past(acc_way));

  p_isolate_r6: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(acc_en) && $past(acc_set) != qry_set && $stable(qry_set))
      |-> $stable(victim));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(acc_en) && $stable(qry_set)) |-> $stable(victim));

  always_comb begin
    if (seen && !rst) begin
      a_known_r2: assert (!$isunknown(victim));
    end
  end
endmodule

bind plru_tree_repl plru_tree_repl_chk #(.SET_W(SET_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .acc_en  (acc_en),
  .acc_set (acc_set),
  .acc_way (acc_way),
  .qry_set (qry_set),
  .victim  (victim)
);

// File: tb/tb_plru_tree_repl.sv
module tb_plru_tree_repl;
  localparam int NS = 64;
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_en;
  logic [SW-1:0] acc_set;
  logic [1:0]    acc_way;
  logic [SW-1:0] qry_set;
  logic [1:0]    victim;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Reference: tree bits per R3 as {root, lo, hi}; recency list per R5 (index 0 = most recent)
  logic [2:0] mb  [NS];
  int         rec [NS][4];

  always #5 clk = ~clk;

  plru_tree_repl #(.NUM_SETS(NS)) dut (
    .clk     (clk),
    .rst     (rst),
    .acc_en  (acc_en),
    .acc_set (acc_set),
    .acc_way (acc_way),
    .qry_set (qry_set),
    .victim  (victim)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_victim(input int s);
    logic [2:0] b = mb[s];
    return b[2] ? (2 + int'(b[0])) : int'(b[1]);
  endfunction

  function automatic void model_reset();
    for (int s = 0; s < NS; s++) begin
      mb[s] = 3'b000;
      rec[s][0] = 3; rec[s][1] = 1; rec[s][2] = 2; rec[s][3] = 0;
    end
  endfunction

  function automatic void model_access(input int s, input int w);
    int pos = 0;
    mb[s][2] = ~w[1];
    if (w[1]) mb[s][0] = ~w[0];
    else      mb[s][1] = ~w[0];
    for (int i = 0; i < 4; i++) if (rec[s][i] == w) pos = i;
    for (int i = pos; i > 0; i--) rec[s][i] = rec[s][i-1];
    rec[s][0] = w;
  endfunction

  // drive at negedge, one access per cycle; check at the next negedge
  task automatic do_access(input int s, input int w);
    @(negedge clk);
    acc_en = 1'b1; acc_set = SW'(s); acc_way = 2'(w);
    @(negedge clk);
    acc_en = 1'b0;
    model_access(s, w);
  endtask

  task automatic query_chk(input string req, input int s, input int exp);
    qry_set = SW'(s);
    #1;
    chk(req, int'(victim), exp);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; acc_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic t_reset_state();
    apply_reset();
    for (int s = 0; s < NS; s += 7) query_chk("R1 victim after reset", s, 0);
  endtask

  task automatic t_directed_paths();
    // set 5 from reset: way0 -> 2, way2 -> 1, way1 -> 3, way3 -> 0
    do_access(5, 0); query_chk("R3 access way0", 5, 2);
    do_access(5, 2); query_chk("R3 access way2 keeps lo leaf", 5, 1);
    do_access(5, 1); query_chk("R2 access way1 keeps hi leaf", 5, 3);
    do_access(5, 3); query_chk("R2 access way3", 5, 0);
    do_access(5, 0); query_chk("R4 victim not way0", 5, 2);
  endtask

  task automatic t_isolation();
    do_access(9, 1);
    query_chk("R6 neighbour set 8 untouched", 8, exp_victim(8));
    query_chk("R6 neighbour set 10 untouched", 10, 0);
    query_chk("R6 accessed set 9", 9, exp_victim(9));
  endtask

  task automatic t_idle_hold();
    do_access(12, 2);
    query_chk("R7 before idle", 12, exp_victim(12));
    repeat (5) @(negedge clk);
    acc_way = 2'd3; acc_set = SW'(12);  // strobe low: must be ignored
    repeat (3) @(negedge clk);
    query_chk("R7 no change while idle", 12, exp_victim(12));
  endtask

  task automatic t_same_cycle();
    int old_v;
    old_v = exp_victim(20);
    @(negedge clk);
    acc_en = 1'b1; acc_set = SW'(20); acc_way = 2'(old_v);
    qry_set = SW'(20);
    #1;
    chk("R8 old state during strobe", int'(victim), old_v);
    @(negedge clk);
    acc_en = 1'b0;
    model_access(20, old_v);
    query_chk("R8 new state after edge", 20, exp_victim(20));
  endtask

  task automatic t_random();
    for (int n = 0; n < 3000; n++) begin
      int s, w, q, v;
      bit en;
      @(negedge clk);
      en = ($urandom % 4) != 0;
      s  = (n % 5 == 0) ? int'($urandom % NS) : int'($urandom % 4);
      w  = int'($urandom % 4);
      q  = (n % 2 == 0) ? s : int'($urandom % 4);
      acc_en = en; acc_set = SW'(s); acc_way = 2'(w); qry_set = SW'(q);
      #1;
      v = int'(victim);
      chk("R2 random victim", v, exp_victim(q));
      chk("R4 random not most recent", int'(v == rec[q][0]), 0);
      chk("R5 random among two least recent",
          int'(v == rec[q][2] || v == rec[q][3]), 1);
      if (en) model_access(s, w);
    end
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic t_mid_reset();
    do_access(3, 0);
    do_access(3, 3);
    apply_reset();
    for (int s = 0; s < 6; s++) query_chk("R9 reset mid-run", s, 0);
  endtask

  initial begin
    rst = 1'b1; acc_en = 1'b0; acc_set = '0; acc_way = '0; qry_set = '0;
    model_reset();
    t_reset_state();
    t_directed_paths();
    t_isolation();
    t_idle_hold();
    t_same_cycle();
    t_random();
    t_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run completion actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule